// File: doc/BRIEF.md
# Floating-Point Load/Store Address and Alignment Checker

This block screens one floating-point load or store per strobe, before any memory access is made. From the decoded instruction fields and the two source register values it forms the effective address, picks the address space identifier, tells loads from stores and decides whether the access is legal. The alignment rule depends on the size code, the destination register field and the current data model, all taken together.

Alternate-space accesses that name an identifier above the highest architecturally defined one (0x8B) are sent to a separate implementation-specific handler through a divert flag instead of being checked. When the access is accepted, the block returns an advanced program counter pair so that the instruction is not retried. When it traps or diverts, the pair is returned unchanged. All results appear, registered, one cycle after the input strobe.

Top module: `fp_ldst_check`

## Requirements
- R1: `valid_o` is high in exactly the cycle after each cycle with `valid_i` high, and the result fields it qualifies belong to that strobe.
- R2: With `imm_sel_i`=0 the address `addr_o` is `rs1_val_i + rs2_val_i`, modulo 2^64.
- R3: With `imm_sel_i`=1 the address is `rs1_val_i` plus `insn_lo_i[12:0]` sign-extended to 64 bits.
- R4: When `op3_i[4]`=1 (alternate space), `asi_o` is `state_asi_i` if `imm_sel_i`=1 and `insn_lo_i[12:5]` if `imm_sel_i`=0. When `op3_i[4]`=0, `asi_o` is 0.
- R5: `divert_o` is 1 exactly when `op3_i[5:4]`=2'b11 and the selected identifier is greater than 0x8B. A diverted access never has `align_trap_o` set.
- R6: For size code `op3_i[1:0]`=0 (word) or 2 (quad), `align_trap_o` is set when address bits [1:0] are nonzero.
- R7: For size code 1 (status register), `align_trap_o` is set when `rd_i`=0 and address bits [1:0] are nonzero, or when `rd_i`≠0 and address bits [2:0] are nonzero.
- R8: For size code 3 (double), `align_trap_o` is set on nonzero address bits [2:0] when `narrow_model_i`=1, and on nonzero address bits [1:0] when it is 0.
- R9: `is_store_o` equals `op3_i[2]` (1 = store, 0 = load).
- R10: Without trap and divert, `pc_o` = `npc_i` and `npc_o` = `npc_i` + 4; otherwise `pc_o` = `pc_i` and `npc_o` = `npc_i`.
- R11: While `rst_ni` is low all outputs are 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction strobe |
| op3_i | input | 6 | Opcode field: [5:4] space class, [2] store, [1:0] size |
| imm_sel_i | input | 1 | Immediate-form select bit |
| insn_lo_i | input | 13 | Instruction bits [12:0]: immediate, or identifier in [12:5] |
| rd_i | input | 5 | Destination register field |
| rs1_val_i | input | 64 | First source register value |
| rs2_val_i | input | 64 | Second source register value |
| state_asi_i | input | 8 | Default identifier from processor state |
| narrow_model_i | input | 1 | 1 = 32-bit data model |
| pc_i | input | 64 | Current program counter |
| npc_i | input | 64 | Next program counter |
| valid_o | output | 1 | Result valid |
| addr_o | output | 64 | Effective address |
| asi_o | output | 8 | Selected address space identifier |
| is_store_o | output | 1 | Direction: 1 = store |
| align_trap_o | output | 1 | Misaligned access |
| divert_o | output | 1 | Sent to implementation-specific handler |
| pc_o | output | 64 | Resulting program counter |
| npc_o | output | 64 | Resulting next program counter |

## Verification
Every result register is loaded only on a strobe, so a wrong address sum, identifier pick or size decode shows up on the very next `valid_o` cycle for the one instruction that caused it, and never contaminates a later one. A mistaken trap or divert decision is visible twice in that same cycle: once on the flag and again as an unadvanced or wrongly advanced `pc_o`/`npc_o` pair. The bench therefore aims its vectors at the edges of each decision: identifier 0x8B against 0x8C, the non-alternate class with a large identifier, and addresses offset by 4 against the 8-byte forms under both data models.

// File: rtl/fp_ldst_pkg.sv
package fp_ldst_pkg;
  typedef enum logic [1:0] {
    SZ_WORD   = 2'd0,
    SZ_STATUS = 2'd1,
    SZ_QUAD   = 2'd2,
    SZ_DOUBLE = 2'd3
  } size_e;
endpackage

// File: rtl/fp_ldst_ea.sv
module fp_ldst_ea #(
  parameter int AW    = 64,
  parameter int IMM_W = 13
) (
  input  logic             imm_sel_i,
  input  logic [AW-1:0]    rs1_i,
  input  logic [AW-1:0]    rs2_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [AW-1:0]    addr_o
);
  localparam int EXT_W = AW - IMM_W;
  logic [AW-1:0] opnd_b;

  assign opnd_b = imm_sel_i ? {{EXT_W{imm_i[IMM_W-1]}}, imm_i} : rs2_i;
  assign addr_o = rs1_i + opnd_b;
endmodule

// File: rtl/fp_ldst_asi.sv
module fp_ldst_asi #(
  parameter int          ASI_W     = 8,
  parameter logic [7:0]  ASI_LIMIT = 8'h8B
) (
  input  logic [1:0]       space_i,   // op3[5:4]
  input  logic             imm_sel_i,
  input  logic [ASI_W-1:0] state_asi_i,
  input  logic [ASI_W-1:0] insn_asi_i,
  output logic [ASI_W-1:0] asi_o,
  output logic             divert_o
);
  localparam logic [ASI_W-1:0] LIMIT = ASI_W'(ASI_LIMIT);
  logic alt;

  assign alt      = space_i[0];
  assign asi_o    = !alt ? '0 : (imm_sel_i ? state_asi_i : insn_asi_i);
  assign divert_o = (space_i == 2'b11) && (asi_o > LIMIT);
endmodule

// File: rtl/fp_ldst_align.sv
module fp_ldst_align
  import fp_ldst_pkg::*;
#(
  parameter int RD_W = 5
) (
  input  size_e           size_i,
  input  logic [RD_W-1:0] rd_i,
  input  logic            narrow_i,
  input  logic [2:0]      addr_lo_i,
  input  logic            divert_i,
  output logic            trap_o
);
  logic need8;

  always_comb begin
    unique case (size_i)
      SZ_STATUS: need8 = (rd_i != '0);
      SZ_DOUBLE: need8 = narrow_i;
      default:   need8 = 1'b0;
    endcase
  end

  // diverted accesses skip the check
  assign trap_o = !divert_i &&
                  ((addr_lo_i[1:0] != 2'b00) || (need8 && addr_lo_i[2]));
endmodule

// File: rtl/fp_ldst_check.sv
module fp_ldst_check
  import fp_ldst_pkg::*;
#(
  parameter int         AW        = 64,
  parameter int         ASI_W     = 8,
  parameter int         IMM_W     = 13,
  parameter int         RD_W      = 5,
  parameter logic [7:0] ASI_LIMIT = 8'h8B,
  parameter int         STEP      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [5:0]       op3_i,
  input  logic             imm_sel_i,
  input  logic [IMM_W-1:0] insn_lo_i,
  input  logic [RD_W-1:0]  rd_i,
  input  logic [AW-1:0]    rs1_val_i,
  input  logic [AW-1:0]    rs2_val_i,
  input  logic [ASI_W-1:0] state_asi_i,
  input  logic             narrow_model_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [AW-1:0]    npc_i,
  output logic             valid_o,
  output logic [AW-1:0]    addr_o,
  output logic [ASI_W-1:0] asi_o,
  output logic             is_store_o,
  output logic             align_trap_o,
  output logic             divert_o,
  output logic [AW-1:0]    pc_o,
  output logic [AW-1:0]    npc_o
);
  localparam int ASI_LSB = 5;
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0]    ea;
  logic [ASI_W-1:0] asi_sel;
  logic             div_c, trap_c, ok_c;
  logic [AW-1:0]    pc_c, npc_c;
  logic             unused_op3_b3;

  assign unused_op3_b3 = op3_i[3];

  fp_ldst_ea #(.AW(AW), .IMM_W(IMM_W)) i_ea (
    .imm_sel_i (imm_sel_i),
    .rs1_i     (rs1_val_i),
    .rs2_i     (rs2_val_i),
    .imm_i     (insn_lo_i),
    .addr_o    (ea)
  );

  fp_ldst_asi #(.ASI_W(ASI_W), .ASI_LIMIT(ASI_LIMIT)) i_asi (
    .space_i     (op3_i[5:4]),
    .imm_sel_i   (imm_sel_i),
    .state_asi_i (state_asi_i),
    .insn_asi_i  (insn_lo_i[ASI_LSB +: ASI_W]),
    .asi_o       (asi_sel),
    .divert_o    (div_c)
  );

  fp_ldst_align #(.RD_W(RD_W)) i_align (
    .size_i    (size_e'(op3_i[1:0])),
    .rd_i      (rd_i),
    .narrow_i  (narrow_model_i),
    .addr_lo_i (ea[2:0]),
    .divert_i  (div_c),
    .trap_o    (trap_c)
  );

  assign ok_c  = !trap_c && !div_c;
  assign pc_c  = ok_c ? npc_i : pc_i;
  assign npc_c = ok_c ? npc_i + STEP_V : npc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      addr_o       <= '0;
      asi_o        <= '0;
      is_store_o   <= 1'b0;
      align_trap_o <= 1'b0;
      divert_o     <= 1'b0;
      pc_o         <= '0;
      npc_o        <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        addr_o       <= ea;
        asi_o        <= asi_sel;
        is_store_o   <= op3_i[2];
        align_trap_o <= trap_c;
        divert_o     <= div_c;
        pc_o         <= pc_c;
        npc_o        <= npc_c;
      end
    end
  end

  p_valid_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_trap_div_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(align_trap_o && divert_o));
  p_store_dir_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (is_store_o == $past(op3_i[2])));
  p_reg_sum_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !imm_sel_i) |=> (addr_o == $past(rs1_val_i) + $past(rs2_val_i)));
  p_advance_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((align_trap_o || divert_o) ?
                 (pc_o == $past(pc_i) && npc_o == $past(npc_i)) :
                 (pc_o == $past(npc_i) && npc_o == $past(npc_i) + STEP_V)));
  p_no_div_alt0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op3_i[5:4] != 2'b11) |=> !divert_o);
endmodule

// File: tb/test_fp_ldst_check.sv
module test_fp_ldst_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [5:0]  op3 = '0;
  logic        isel = 1'b0;
  logic [12:0] insn = '0;
  logic [4:0]  rd = '0;
  logic [63:0] rs1 = '0, rs2 = '0, pc = '0, npc = '0;
  logic [7:0]  sasi = '0;
  logic        narrow = 1'b0;

  logic        valid_o, store_o, trap_o, div_o;
  logic [63:0] addr_o, pc_o, npc_o;
  logic [7:0]  asi_o;

  typedef struct {
    int          cyc;
    logic        isel;
    logic [1:0]  size;
    logic [63:0] addr;
    logic [7:0]  asi;
    logic        store, trap, div;
    logic [63:0] pc, npc;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fp_ldst_check i_fp_ldst_check (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op3_i(op3),
    .imm_sel_i(isel), .insn_lo_i(insn), .rd_i(rd), .rs1_val_i(rs1),
    .rs2_val_i(rs2), .state_asi_i(sasi), .narrow_model_i(narrow),
    .pc_i(pc), .npc_i(npc), .valid_o(valid_o), .addr_o(addr_o),
    .asi_o(asi_o), .is_store_o(store_o), .align_trap_o(trap_o),
    .divert_o(div_o), .pc_o(pc_o), .npc_o(npc_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected results straight from the requirements
  function automatic exp_t model(logic [5:0] o, logic i, logic [12:0] ins,
                                 logic [4:0] r, logic [63:0] a, logic [63:0] b,
                                 logic [7:0] sa, logic nm, logic [63:0] p, logic [63:0] np);
    exp_t e;
    logic need8;
    e.cyc   = 0;
    e.isel  = i;
    e.size  = o[1:0];
    e.addr  = i ? a + {{51{ins[12]}}, ins} : a + b;                      // R2 R3
    e.asi   = !o[4] ? 8'h00 : (i ? sa : ins[12:5]);                      // R4
    e.div   = (o[5:4] == 2'b11) && (e.asi > 8'h8B);                      // R5
    need8   = (o[1:0] == 2'd1) ? (r != 0) : (o[1:0] == 2'd3) ? nm : 1'b0; // R7 R8
    e.trap  = !e.div && ((e.addr[1:0] != 0) || (need8 && e.addr[2]));    // R6
    e.store = o[2];                                                      // R9
    e.pc    = (e.trap || e.div) ? p : np;                                // R10
    e.npc   = (e.trap || e.div) ? np : np + 64'd4;
    return e;
  endfunction

  task automatic drive(logic [5:0] o, logic i, logic [12:0] ins, logic [4:0] r,
                       logic [63:0] a, logic [63:0] b, logic [7:0] sa, logic nm);
    exp_t e;
    logic [63:0] p, np;
    p  = 64'h4000 + 64'(cyc) * 8;
    np = p + 4;
    @(negedge clk);
    valid_i = 1'b1; op3 = o; isel = i; insn = ins; rd = r;
    rs1 = a; rs2 = b; sasi = sa; narrow = nm; pc = p; npc = np;
    e = model(o, i, ins, r, a, b, sa, nm, p, np);
    e.cyc = cyc + 1;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
    op3 = $urandom; rs1 = {$urandom, $urandom};
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && valid_o) begin
        if (q.size() == 0) begin
          chk("R1 unexpected valid_o", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk("R1 latency", 64'(cyc), 64'(e.cyc));
          chk(e.isel ? "R3 addr" : "R2 addr", addr_o, e.addr);
          chk("R4 asi", 64'(asi_o), 64'(e.asi));
          chk("R5 divert", 64'(div_o), 64'(e.div));
          chk(e.size == 2'd1 ? "R7 trap" : e.size == 2'd3 ? "R8 trap" : "R6 trap",
              64'(trap_o), 64'(e.trap));
          chk("R9 store", 64'(store_o), 64'(e.store));
          chk("R10 pc", pc_o, e.pc);
          chk("R10 npc", npc_o, e.npc);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 valid_o", 64'(valid_o), 64'd0);
    chk("R11 addr_o", addr_o, 64'd0);
    chk("R11 pc_o", pc_o, 64'd0);
    chk("R11 npc_o", npc_o, 64'd0);
    chk("R11 flags", 64'({asi_o, store_o, trap_o, div_o}), 64'd0);
    rst_n = 1'b1;
    idle();
    // R2 R6 word aligned / misaligned
    drive(6'h00, 0, 13'h0,    0, 64'h1000, 64'h24, 8'h00, 0);
    drive(6'h00, 0, 13'h0,    0, 64'h1000, 64'h22, 8'h00, 0);
    // R3 negative immediate
    drive(6'h00, 1, 13'h1FFC, 0, 64'h2000, 64'h0,  8'h00, 0);
    // R3 wrap below zero
    drive(6'h00, 1, 13'h1000, 0, 64'h10,   64'h0,  8'h00, 0);
    // R6 quad only needs 4
    drive(6'h02, 0, 13'h0,    0, 64'h3004, 64'h0,  8'h00, 1);
    // R7 status forms
    drive(6'h01, 0, 13'h0,    0, 64'h3004, 64'h0,  8'h00, 0);
    drive(6'h01, 0, 13'h0,    1, 64'h3004, 64'h0,  8'h00, 0);
    drive(6'h01, 0, 13'h0,    1, 64'h3008, 64'h0,  8'h00, 0);
    // R8 double under both models
    drive(6'h03, 0, 13'h0,    0, 64'h3004, 64'h0,  8'h00, 1);
    drive(6'h03, 0, 13'h0,    0, 64'h3004, 64'h0,  8'h00, 0);
    // R9 store word
    drive(6'h24, 0, 13'h0,    0, 64'h3000, 64'h0,  8'h00, 0);
    idle();
    // R4 identifier from instruction bits, and from state
    drive(6'h30, 0, 13'h1000, 0, 64'h5000, 64'h8,  8'h77, 0);
    drive(6'h30, 1, 13'h0008, 0, 64'h5000, 64'h0,  8'h42, 0);
    // R5 divert above limit, misaligned address but no trap
    drive(6'h30, 1, 13'h0001, 0, 64'h5000, 64'h0,  8'h8C, 0);
    // R5 boundary 0x8B not diverted
    drive(6'h30, 0, 13'h1160, 0, 64'h5000, 64'h4,  8'h00, 0);
    // R5 alternate class 01 never diverted
    drive(6'h11, 1, 13'h0002, 0, 64'h5000, 64'h0,  8'hFF, 0);
    // R4 non-alternate gives zero identifier
    drive(6'h00, 1, 13'h0004, 0, 64'h5000, 64'h0,  8'h55, 0);
    idle(); idle();
    for (int k = 0; k < 60; k++) begin
      drive(6'($urandom), 1'($urandom), 13'($urandom), 5'($urandom % 3),
            {$urandom, $urandom}, 64'($urandom % 16), 8'($urandom), 1'($urandom));
      if (k % 7 == 0) idle();
    end
    idle();
    repeat (4) @(negedge clk);
    chk("R1 drained", 64'(q.size()), 64'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule